// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a two-wire serial bus slave. It gives an external bus master read and write access to a bank of 8-bit registers that sits behind a plain synchronous register port. SCL and SDA are oversampled by the faster system clock through two-flop synchronizers. START, repeated START and STOP are decoded from the synchronized lines, and the slave takes part only in transfers whose 7-bit device address equals the `DEV_ADDR` parameter. SDA is never driven high. The block only asserts an output enable that pulls the line low.

In a write transfer, the byte after the device address loads an internal word pointer, and each later byte is written to the register the pointer selects. The pointer survives a repeated START. A master can therefore load the pointer in a short write and then switch to read mode for random-access reads. After every data byte, in either direction, only the low `STEP_W` bits of the pointer advance. They wrap inside a page of 2^`STEP_W` registers, and the upper bits stay fixed.

Top module: `i2c_reg_slave`

## Requirements
- R1: Out of reset, and while no transfer is in progress, `sda_oe_o`, `reg_we_o` and `reg_re_o` are low.
- R2: The first byte after a START or repeated START is taken MSB first as seven address bits and then the direction bit (0 = write, 1 = read). The slave pulls SDA low through the ninth clock only when the seven address bits equal `DEV_ADDR`.
- R3: On an address mismatch the slave gives no acknowledge, never drives SDA and makes no register access until the next START or STOP. Its pointer is left unchanged.
- R4: In a write transfer, the second byte loads the word pointer in full and is acknowledged.
- R5: Each further complete byte of a write transfer is acknowledged and written with one single-cycle `reg_we_o` pulse. The pulse carries the byte on `reg_wdata_o` and the pointer on `reg_addr_o`.
- R6: After every data byte written or transmitted, the low `STEP_W` (default 4) pointer bits increment modulo 2^`STEP_W`, and the upper bits keep their value.
- R7: In a read transfer, the slave acknowledges and sends the register at the pointer MSB first. The pointer keeps its value across repeated START and across STOP.
- R8: During a read, a master acknowledge (SDA low on the ninth clock) makes the slave send the next register. A NACK makes it release SDA and stay silent until START or STOP.
- R9: A START or STOP that arrives part way through a byte discards that byte. No register is written and the pointer does not change.
- R10: `sda_oe_o` changes only while the synchronized SCL is low, so SDA is never disturbed during a high clock phase.
- R11: The register port reads with a single-cycle `reg_re_o` pulse and takes `reg_rdata_i` on the following clock. A read and a write never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| reg_addr_o | output | AW | Register index, the word pointer |
| reg_we_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid the cycle after `reg_re_o` |

## Verification
A wrong pointer shows at the register port at once. The next write strobe carries a wrong `reg_addr_o`, or the next byte the master reads holds another register's value, within one byte time of the error. A wrong protocol state shows on SDA as a missing or extra acknowledge in the ninth clock of the same byte, or as the slave pulling SDA low when it should be silent. The bench mirrors the register bank and the pointer in behavioural form and checks every write strobe and every bus sample against them.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_slv_line.sv
module i2c_slv_line #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_s_o,
  output logic line_q_o
);
  // chain[STAGES-1] is the synchronized value, chain[STAGES] is one clock older
  logic [STAGES:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '1;
    else         chain <= {chain[STAGES-1:0], line_i};
  end

  assign line_s_o = chain[STAGES-1];
  assign line_q_o = chain[STAGES];
endmodule

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw, now_s, prev_s;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_slv_line #(.STAGES(STAGES)) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (raw[g]),
      .line_s_o(now_s[g]),
      .line_q_o(prev_s[g])
    );
  end

  assign scl_s_o    = now_s[0];
  assign sda_s_o    = now_s[1];
  assign scl_rise_o = now_s[0] & ~prev_s[0];
  assign scl_fall_o = ~now_s[0] & prev_s[0];
  assign start_o    = now_s[0] & prev_s[0] & prev_s[1] & ~now_s[1];
  assign stop_o     = now_s[0] & prev_s[0] & ~prev_s[1] & now_s[1];
endmodule

// File: rtl/i2c_slv_ptr.sv
module i2c_slv_ptr #(
  parameter int AW     = 8,
  parameter int STEP_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, ptr_nxt;

  if (STEP_W >= AW) begin : g_full
    assign ptr_nxt = ptr_q + AW'(1);
  end else begin : g_page
    assign ptr_nxt = {ptr_q[AW-1:STEP_W], ptr_q[STEP_W-1:0] + STEP_W'(1)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (step_i) ptr_q <= ptr_nxt;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_s_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              re_o,
  output logic              ptr_load_o,
  output logic [BYTE_W-1:0] ptr_val_o,
  output logic              ptr_step_o,
  output slv_state_e        st_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  slv_state_e        st_q, ack_nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, buf_q, wdata_q;
  logic              oe_q, we_q, load_q, fetch_q, rd_step_q, re_d_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ack_nxt_q <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      buf_q     <= '0;
      wdata_q   <= '0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      load_q    <= 1'b0;
      fetch_q   <= 1'b0;
      rd_step_q <= 1'b0;
      re_d_q    <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      we_q      <= 1'b0;
      load_q    <= 1'b0;
      rd_step_q <= 1'b0;
      fetch_q   <= rd_step_q;   // read the stepped pointer one cycle later
      re_d_q    <= fetch_q;
      if (re_d_q) buf_q <= rdata_i;

      if (stop_i) begin
        st_q  <= ST_IDLE;
        oe_q  <= 1'b0;
        cnt_q <= '0;
      end else if (start_i) begin
        st_q  <= ST_ADDR;
        oe_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WADDR, ST_WDATA: begin
            if (scl_rise_i && cnt_q != FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i && cnt_q == FULL) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                  oe_q <= 1'b1;
                  st_q <= ST_ACK;
                  if (sh_q[0]) begin
                    ack_nxt_q <= ST_TX;
                    fetch_q   <= 1'b1;
                  end else begin
                    ack_nxt_q <= ST_WADDR;
                  end
                end else begin
                  st_q <= ST_IGNORE;
                end
              end else if (st_q == ST_WADDR) begin
                load_q    <= 1'b1;
                oe_q      <= 1'b1;
                st_q      <= ST_ACK;
                ack_nxt_q <= ST_WDATA;
              end else begin
                we_q      <= 1'b1;
                wdata_q   <= sh_q;
                oe_q      <= 1'b1;
                st_q      <= ST_ACK;
                ack_nxt_q <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              st_q  <= ack_nxt_q;
              cnt_q <= '0;
              if (ack_nxt_q == ST_TX) begin
                sh_q <= buf_q;
                oe_q <= ~buf_q[BYTE_W-1];
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                oe_q      <= 1'b0;
                st_q      <= ST_RACK;
                rd_step_q <= 1'b1;
                cnt_q     <= '0;
              end else begin
                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                st_q  <= ST_TX;
                sh_q  <= buf_q;
                oe_q  <= ~buf_q[BYTE_W-1];
                cnt_q <= '0;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign we_o       = we_q;
  assign wdata_o    = wdata_q;
  assign re_o       = fetch_q;
  assign ptr_load_o = load_q;
  assign ptr_val_o  = sh_q;
  assign ptr_step_o = we_q | rd_step_q;
  assign st_o       = st_q;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         SYNC_STAGES = 2,
  parameter int         AW          = 8,
  parameter int         STEP_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_re_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              ptr_load, ptr_step;
  logic [BYTE_W-1:0] ptr_val;
  logic [AW-1:0]     ptr;
  slv_state_e        st;

  i2c_slv_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s_o   (scl_s),
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  i2c_slv_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (bus_start),
    .stop_i    (bus_stop),
    .sda_s_i   (sda_s),
    .rdata_i   (reg_rdata_i),
    .sda_oe_o  (sda_oe_o),
    .we_o      (reg_we_o),
    .wdata_o   (reg_wdata_o),
    .re_o      (reg_re_o),
    .ptr_load_o(ptr_load),
    .ptr_val_o (ptr_val),
    .ptr_step_o(ptr_step),
    .st_o      (st)
  );

  i2c_slv_ptr #(.AW(AW), .STEP_W(STEP_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ptr_load),
    .load_val_i(AW'(ptr_val)),
    .step_i    (ptr_step),
    .ptr_o     (ptr)
  );

  assign reg_addr_o = ptr;
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2c_slv_pkg::*;
#(
  parameter int AW     = 8,
  parameter int STEP_W = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          reg_we_o,
  input logic          reg_re_o,
  input slv_state_e    st,
  input logic [AW-1:0] ptr,
  input logic          ptr_step
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> (!sda_oe_o && !reg_we_o));

  p_ignore_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IGNORE) |-> (!sda_oe_o && !reg_we_o && !reg_re_o));

  p_we_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_ptr_page_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_step |=> (ptr[AW-1:STEP_W] == $past(ptr[AW-1:STEP_W])) &&
                 (ptr[STEP_W-1:0] == STEP_W'($past(ptr[STEP_W-1:0]) + 1'b1)));

  p_oe_hold_scl_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  p_rd_wr_apart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  p_re_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(AW), .STEP_W(STEP_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_s   (scl_s),
  .sda_oe_o(sda_oe_o),
  .reg_we_o(reg_we_o),
  .reg_re_o(reg_re_o),
  .st      (st),
  .ptr     (ptr),
  .ptr_step(ptr_step)
);

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;
  localparam logic [6:0] DEV = 7'h52;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire  sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave #(.DEV_ADDR(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_we_o(reg_we),
    .reg_wdata_o(reg_wdata), .reg_re_o(reg_re), .reg_rdata_i(reg_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] wr_q [$];
  bit quiet = 0;
  int quiet_bad = 0;

  function automatic logic [7:0] seed_val(int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  // register bank behind the port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed_val(i);
      reg_rdata <= 8'h00;
    end else begin
      if (reg_re) reg_rdata <= mem[reg_addr];
      if (reg_we) mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // every write strobe is compared with the model's next expected write (R5)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wr_q.size() == 0) begin
        chk(0, "R5", "unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = wr_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R5", "write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
    if (quiet && sda_oe) quiet_bad++;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic do_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic send_bit(bit b);
    sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq();
  endtask

  task automatic tx_byte(logic [7:0] d, output bit ack_line);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack_line);
  endtask

  task automatic rx_byte(bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!give_ack);
  endtask

  task automatic wr_data(logic [7:0] ptr, logic [7:0] d);
    bit a;
    wr_q.push_back({ptr, d});
    exp_mem[ptr] = d;
    tx_byte(d, a);
    chk(a == 0, "R5", "data byte ack", a, 0);
  endtask

  function automatic logic [7:0] page_step(logic [7:0] p);
    return {p[7:4], 4'(p[3:0] + 1)};
  endfunction

  task automatic rd_data(bit give_ack, inout logic [7:0] ptr, input string req);
    logic [7:0] d;
    rx_byte(give_ack, d);
    chk(d == exp_mem[ptr], req, "read byte", d, exp_mem[ptr]);
    ptr = page_step(ptr);
  endtask

  task automatic set_ptr(logic [7:0] p);
    bit a;
    do_start();
    tx_byte({DEV, 1'b0}, a); chk(a == 0, "R2", "write address ack", a, 0);
    tx_byte(p, a);           chk(a == 0, "R4", "pointer byte ack", a, 0);
  endtask

  task automatic rd_head();
    bit a;
    do_start();
    tx_byte({DEV, 1'b1}, a); chk(a == 0, "R2", "read address ack", a, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] p, d;
    bit a;
    for (int i = 0; i < 256; i++) exp_mem[i] = seed_val(i);
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R1", "oe in reset", sda_oe, 0);
    chk(reg_we == 0 && reg_re == 0, "R1", "port idle in reset", {reg_we, reg_re}, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(sda_oe == 0, "R1", "oe after reset", sda_oe, 0);

    // burst write that wraps inside the page (R4 R5 R6)
    set_ptr(8'h3E);
    p = 8'h3E;
    wr_data(p, 8'hA1); p = page_step(p);
    wr_data(p, 8'hB2); p = page_step(p);
    wr_data(p, 8'hC3); p = page_step(p);
    do_stop();
    chk(wr_q.size() == 0, "R5", "writes pending", wr_q.size(), 0);

    // random read across a repeated START, ack ack nack (R7 R6 R8)
    set_ptr(8'h3F);
    p = 8'h3F;
    rd_head();
    rd_data(1, p, "R7");
    rd_data(1, p, "R6");
    rd_data(0, p, "R8");
    quiet = 1; quiet_bad = 0;
    recv_bit(a);
    chk(a == 1, "R8", "SDA released after NACK", a, 1);
    quiet = 0;
    chk(quiet_bad == 0, "R8", "oe cycles after NACK", quiet_bad, 0);
    do_stop();

    // pointer kept across STOP (R7)
    rd_head();
    rd_data(0, p, "R7");
    do_stop();

    // mismatching device addresses (R3)
    quiet = 1; quiet_bad = 0;
    do_start();
    tx_byte({7'h21, 1'b0}, a); chk(a == 1, "R3", "no ack on mismatch", a, 1);
    tx_byte(8'h10, a);         chk(a == 1, "R3", "no ack on ignored byte", a, 1);
    tx_byte(8'h55, a);         chk(a == 1, "R3", "no ack on ignored byte", a, 1);
    do_start();
    tx_byte({DEV ^ 7'h01, 1'b1}, a); chk(a == 1, "R3", "no ack low bit mismatch", a, 1);
    do_stop();
    quiet = 0;
    chk(quiet_bad == 0, "R3", "oe cycles while ignored", quiet_bad, 0);
    rd_head();
    rd_data(0, p, "R3");
    do_stop();

    // partial byte cut by repeated START (R9)
    set_ptr(8'h70);
    p = 8'h70;
    wr_data(p, 8'h99); p = page_step(p);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    rd_head();
    rd_data(0, p, "R9");
    do_stop();
    chk(wr_q.size() == 0, "R9", "writes pending", wr_q.size(), 0);

    // partial byte cut by STOP (R9)
    set_ptr(8'h80);
    p = 8'h80;
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    do_stop();
    rd_head();
    rd_data(0, p, "R9");
    do_stop();

    // upper pointer bits fixed over the wrap (R6)
    set_ptr(8'hAF);
    p = 8'hAF;
    wr_data(p, 8'h11); p = page_step(p);
    wr_data(p, 8'h22); p = page_step(p);
    do_stop();
    chk(p == 8'hA1, "R6", "model pointer", p, 8'hA1);
    set_ptr(8'hAE);
    p = 8'hAE;
    rd_head();
    rd_data(1, p, "R6");
    rd_data(1, p, "R6");
    rd_data(1, p, "R6");
    rd_data(0, p, "R8");
    do_stop();
    repeat (20) @(negedge clk);
    chk(sda_oe == 0 && wr_q.size() == 0, "R1", "idle after traffic", sda_oe, 0);

    d = 8'h00;
    if (d != 0) $display("unused");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule